// File: doc/BRIEF.md
# Three-Channel Threshold Watchdog

This block is a register-mapped watchdog with three channels. Every channel owns an up-counter that advances once per reference tick, a bite threshold and a control word. When a channel's reset enable is set and its count has reached or passed its bite threshold, the channel requests a reset. Channel 0 requests a reset into recovery mode. Channels 1 and 2 share a request for an ordinary system reset.

Channel 0 also has a bark threshold. When its interrupt enable is set and its count reaches that threshold, a sticky status bit is set. The interrupt line is driven from that bit.

Software services a channel by writing zero to its count. Software can also force an immediate reset: it sets reset enable with both the bite threshold and the count at zero. A single-cycle 32-bit write port and an always-valid combinational read port give access to the registers.

Top module: `tri_wdog`

## Requirements
- R1: After the synchronous reset, every count, threshold and control register reads 0 and all three outputs are low.
- R2: A count rises by exactly one on each clock cycle with `tick` high. It holds its value while `tick` is low.
- R3: A count that has reached 0xFFFFFFFF stays there on later ticks.
- R4: A write to a count register loads the written value, even in a cycle where `tick` is high. The new value reads back from the next cycle on.
- R5: A channel requests reset while its reset enable (control bit 2) is 1 and its count is at or above its bite threshold. Channel 0 drives `rst_recovery_req`. Channels 1 and 2 drive `rst_system_req`.
- R6: The channel 0 status bit (control bit 1) is set one cycle after its interrupt enable (control bit 0) is 1 and its count is at or above the bark threshold. `irq` equals status AND enable.
- R7: Writing a 1 to channel 0 control bit 1 clears the status. Writing a 0 there leaves the status unchanged.
- R8: The register map uses these byte offsets:
  - Channel 0: 0x00 count, 0x04 bite, 0x08 bark, 0x0C control.
  - Channel 1: 0x10 count, 0x14 bite, 0x1C control.
  - Channel 2: 0x20 count, 0x24 bite, 0x2C control.
  - Control bits 0 and 1 of channels 1 and 2 always read 0.
- R9: Unmapped offsets read 0 and writes to them change nothing. Examples are 0x18, 0x28 and 0x30 to 0x3F.
- R10: With a bite threshold of 0 and a count of 0, setting reset enable raises the request in the very next cycle.
- R11: A reset request is a level. It stays high until a register write removes the condition, for example a write of 0 to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick enable, one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_recovery_req | output | 1 | Recovery-mode reset request from channel 0 |
| rst_system_req | output | 1 | System reset request from channels 1 and 2 |
| irq | output | 1 | Channel 0 bark interrupt |

## Verification
A count register that slips or wraps shows up at once on a count read. It also shows up in the cycle the reset request rises too early, too late or falls again after saturation. A status bit held in the wrong state is visible on the channel 0 control read in the cycle after the bark condition. It is also visible on `irq` in that same cycle. Decode faults appear as a non-zero read of an unmapped offset, or as a changed neighbour register right after the stray write.

// File: rtl/tri_wdog_pkg.sv
package tri_wdog_pkg;

    parameter int unsigned DATA_W = 32;
    parameter int unsigned N_CH   = 3;

    localparam int unsigned CH_W    = $clog2(N_CH);
    localparam int unsigned SEL_W   = 2;
    localparam int unsigned ALIGN_W = 2;
    localparam int unsigned ADDR_W  = CH_W + SEL_W + ALIGN_W;

    localparam int unsigned BIT_IRQ_EN = 0;
    localparam int unsigned BIT_IRQ_ST = 1;
    localparam int unsigned BIT_RST_EN = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam word_t CNT_MAX = '1;

    typedef enum logic [SEL_W-1:0] {
        SEL_COUNT = 2'd0,
        SEL_BITE  = 2'd1,
        SEL_BARK  = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rst_en;
        logic irq_st;
        logic irq_en;
    } ctrl_t;

    typedef struct packed {
        logic cnt_we;
        logic bite_we;
        logic bark_we;
        logic ctrl_we;
    } chan_wr_t;

    function automatic logic reached(input word_t value, input word_t limit);
        return value >= limit;
    endfunction

    function automatic word_t ctrl_word(input ctrl_t c);
        word_t w;
        w = '0;
        w[BIT_IRQ_EN] = c.irq_en;
        w[BIT_IRQ_ST] = c.irq_st;
        w[BIT_RST_EN] = c.rst_en;
        return w;
    endfunction

endpackage

// File: rtl/tri_wdog_decode.sv
module tri_wdog_decode
    import tri_wdog_pkg::*;
(
    input  logic                wr_en,
    input  addr_t               addr,
    output chan_wr_t [N_CH-1:0] strb,
    output logic                hit,
    output logic [CH_W-1:0]     ch,
    output reg_sel_e            sel
);

    logic aligned;
    logic ch_ok;
    logic sel_ok;

    always_comb begin
        ch      = addr[ADDR_W-1 -: CH_W];
        sel     = reg_sel_e'(addr[ALIGN_W +: SEL_W]);
        aligned = (addr[ALIGN_W-1:0] == '0);
        ch_ok   = (int'(ch) < int'(N_CH));
        sel_ok  = (sel != SEL_BARK) || (ch == '0);
        hit     = aligned && ch_ok && sel_ok;
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_strb
        logic mine;
        assign mine = wr_en && hit && (int'(ch) == i);
        assign strb[i].cnt_we  = mine && (sel == SEL_COUNT);
        assign strb[i].bite_we = mine && (sel == SEL_BITE);
        assign strb[i].bark_we = mine && (sel == SEL_BARK);
        assign strb[i].ctrl_we = mine && (sel == SEL_CTRL);
    end

endmodule

// File: rtl/tri_wdog_chan.sv
module tri_wdog_chan
    import tri_wdog_pkg::*;
#(
    parameter bit HAS_BARK = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  chan_wr_t strb,
    input  word_t    wdata,
    output word_t    count,
    output word_t    bite,
    output word_t    bark,
    output ctrl_t    ctrl,
    output logic     rst_req,
    output logic     irq
);

    word_t cnt_q;
    word_t bite_q;
    word_t bark_q;
    ctrl_t ctrl_q;
    logic  bark_hit;

    always_comb begin
        bark_hit = HAS_BARK && ctrl_q.irq_en && reached(cnt_q, bark_q);
        rst_req  = ctrl_q.rst_en && reached(cnt_q, bite_q);
        irq      = ctrl_q.irq_st && ctrl_q.irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            bite_q <= '0;
            bark_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (strb.cnt_we) begin
                cnt_q <= wdata;
            end else if (tick && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + word_t'(1);
            end
            if (strb.bite_we) begin
                bite_q <= wdata;
            end
            if (strb.bark_we) begin
                bark_q <= HAS_BARK ? wdata : '0;
            end
            if (strb.ctrl_we) begin
                ctrl_q.rst_en <= wdata[BIT_RST_EN];
                ctrl_q.irq_en <= HAS_BARK && wdata[BIT_IRQ_EN];
            end
            if (bark_hit) begin
                ctrl_q.irq_st <= 1'b1;
            end else if (strb.ctrl_we && wdata[BIT_IRQ_ST]) begin
                ctrl_q.irq_st <= 1'b0;
            end
        end
    end

    assign count = cnt_q;
    assign bite  = bite_q;
    assign bark  = bark_q;
    assign ctrl  = ctrl_q;

endmodule

// File: rtl/tri_wdog_rdmux.sv
module tri_wdog_rdmux
    import tri_wdog_pkg::*;
(
    input  logic              hit,
    input  logic [CH_W-1:0]   ch,
    input  reg_sel_e          sel,
    input  word_t [N_CH-1:0]  counts,
    input  word_t [N_CH-1:0]  bites,
    input  word_t [N_CH-1:0]  barks,
    input  ctrl_t [N_CH-1:0]  ctrls,
    output word_t             rdata
);

    always_comb begin
        rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_COUNT: rdata = counts[ch];
                SEL_BITE:  rdata = bites[ch];
                SEL_BARK:  rdata = barks[ch];
                SEL_CTRL:  rdata = ctrl_word(ctrls[ch]);
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tri_wdog.sv
module tri_wdog
    import tri_wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_recovery_req,
    output logic              rst_system_req,
    output logic              irq
);

    chan_wr_t [N_CH-1:0] strb;
    logic                hit;
    logic [CH_W-1:0]     ch;
    reg_sel_e            sel;
    word_t [N_CH-1:0]    counts;
    word_t [N_CH-1:0]    bites;
    word_t [N_CH-1:0]    barks;
    ctrl_t [N_CH-1:0]    ctrls;
    logic  [N_CH-1:0]    req_v;
    logic  [N_CH-1:0]    irq_v;

    tri_wdog_decode u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .strb  (strb),
        .hit   (hit),
        .ch    (ch),
        .sel   (sel)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        tri_wdog_chan #(
            .HAS_BARK (i == 0)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .strb    (strb[i]),
            .wdata   (wdata),
            .count   (counts[i]),
            .bite    (bites[i]),
            .bark    (barks[i]),
            .ctrl    (ctrls[i]),
            .rst_req (req_v[i]),
            .irq     (irq_v[i])
        );
    end

    tri_wdog_rdmux u_rdmux (
        .hit    (hit),
        .ch     (ch),
        .sel    (sel),
        .counts (counts),
        .bites  (bites),
        .barks  (barks),
        .ctrls  (ctrls),
        .rdata  (rdata)
    );

    assign rst_recovery_req = req_v[0];
    assign rst_system_req   = |req_v[N_CH-1:1];
    assign irq              = |irq_v;

endmodule

// File: rtl/tri_wdog_chk.sv
module tri_wdog_chk
    import tri_wdog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              rst_recovery_req,
    input logic              rst_system_req,
    input logic              irq
);

    logic is_cnt;
    logic is_unmapped;
    logic is_ctrl12;

    always_comb begin
        is_cnt      = (addr[3:0] == 4'h0) && (addr[5:4] != 2'b11);
        is_unmapped = (addr == 6'h18) || (addr == 6'h28) || (addr[5:4] == 2'b11);
        is_ctrl12   = (addr == 6'h1C) || (addr == 6'h2C);
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!irq && !rst_recovery_req && !rst_system_req));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !tick && addr != 6'h0C) |=> ($stable(addr) -> $stable(rdata)));

    p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && addr == 6'h00 && rdata == CNT_MAX) |=>
        (addr != 6'h00 || rdata == CNT_MAX));

    p_write_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_cnt) |=> ($stable(addr) -> rdata == $past(wdata)));

    p_ctrl_bits_r8: assert property (@(posedge clk) disable iff (rst)
        is_ctrl12 |-> (rdata[1:0] == 2'b00));

    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        is_unmapped |-> (rdata == '0));

    p_rec_level_r11: assert property (@(posedge clk) disable iff (rst)
        (rst_recovery_req && !wr_en) |=> rst_recovery_req);

    p_sys_level_r11: assert property (@(posedge clk) disable iff (rst)
        (rst_system_req && !wr_en) |=> rst_system_req);

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_en) |=> irq);

endmodule

bind tri_wdog tri_wdog_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .tick             (tick),
    .wr_en            (wr_en),
    .addr             (addr),
    .wdata            (wdata),
    .rdata            (rdata),
    .rst_recovery_req (rst_recovery_req),
    .rst_system_req   (rst_system_req),
    .irq              (irq)
);

// File: tb/tri_wdog_test.sv
`timescale 1ns/1ps
module tri_wdog_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_recovery_req;
    logic        rst_system_req;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tri_wdog uut (
        .clk              (clk),
        .rst              (rst),
        .tick             (tick),
        .wr_en            (wr_en),
        .addr             (addr),
        .wdata            (wdata),
        .rdata            (rdata),
        .rst_recovery_req (rst_recovery_req),
        .rst_system_req   (rst_system_req),
        .irq              (irq)
    );

    typedef enum logic [2:0] {OP_WR, OP_RD, OP_IDLE, OP_TICK, OP_OUT} op_e;

    typedef struct packed {
        op_e         op;
        logic [3:0]  req;
        logic [5:0]  a;
        logic [31:0] d;
    } vec_t;

    localparam int NV = 61;
    // For OP_RD and OP_OUT the d field is the expected value.
    // OP_OUT compares {irq, rst_system_req, rst_recovery_req}.
    localparam vec_t VECS [NV] = '{
        '{OP_RD,   4'd1,  6'h00, 32'd0},   // R1 count 0 after reset
        '{OP_RD,   4'd1,  6'h0C, 32'd0},   // R1 control 0
        '{OP_OUT,  4'd1,  6'h00, 32'd0},   // R1 outputs low
        '{OP_WR,   4'd4,  6'h00, 32'd10},
        '{OP_RD,   4'd4,  6'h00, 32'd10},  // R4 write loads
        '{OP_TICK, 4'd2,  6'h00, 32'd5},
        '{OP_RD,   4'd2,  6'h00, 32'd15},  // R2 five ticks
        '{OP_IDLE, 4'd2,  6'h00, 32'd3},
        '{OP_RD,   4'd2,  6'h00, 32'd15},  // R2 holds without tick
        '{OP_WR,   4'd5,  6'h14, 32'd20},
        '{OP_WR,   4'd5,  6'h10, 32'd18},
        '{OP_WR,   4'd5,  6'h1C, 32'd4},
        '{OP_OUT,  4'd5,  6'h00, 32'd0},   // R5 below bite
        '{OP_TICK, 4'd5,  6'h00, 32'd2},
        '{OP_OUT,  4'd5,  6'h00, 32'd2},   // R5 ch1 drives system
        '{OP_RD,   4'd8,  6'h1C, 32'd4},   // R8 control layout
        '{OP_WR,   4'd8,  6'h1C, 32'd7},
        '{OP_RD,   4'd8,  6'h1C, 32'd4},   // R8 irq bits absent on ch1
        '{OP_WR,   4'd11, 6'h10, 32'd0},
        '{OP_OUT,  4'd11, 6'h00, 32'd0},   // R11 pet drops request
        '{OP_WR,   4'd6,  6'h08, 32'd30},
        '{OP_WR,   4'd6,  6'h00, 32'd29},
        '{OP_WR,   4'd6,  6'h0C, 32'd1},
        '{OP_IDLE, 4'd6,  6'h00, 32'd1},
        '{OP_RD,   4'd6,  6'h0C, 32'd1},   // R6 below bark
        '{OP_TICK, 4'd6,  6'h00, 32'd1},
        '{OP_IDLE, 4'd6,  6'h00, 32'd1},
        '{OP_RD,   4'd6,  6'h0C, 32'd3},   // R6 status set
        '{OP_OUT,  4'd6,  6'h00, 32'd4},   // R6 irq high
        '{OP_WR,   4'd7,  6'h00, 32'd0},
        '{OP_IDLE, 4'd7,  6'h00, 32'd1},
        '{OP_RD,   4'd7,  6'h0C, 32'd3},   // R7 sticky
        '{OP_WR,   4'd7,  6'h0C, 32'd1},
        '{OP_RD,   4'd7,  6'h0C, 32'd3},   // R7 write 0 keeps status
        '{OP_WR,   4'd7,  6'h0C, 32'd3},
        '{OP_RD,   4'd7,  6'h0C, 32'd1},   // R7 write 1 clears
        '{OP_OUT,  4'd7,  6'h00, 32'd0},
        '{OP_WR,   4'd6,  6'h00, 32'd40},
        '{OP_IDLE, 4'd6,  6'h00, 32'd1},
        '{OP_WR,   4'd6,  6'h0C, 32'd0},
        '{OP_RD,   4'd6,  6'h0C, 32'd2},   // R6 status kept, enable off
        '{OP_OUT,  4'd6,  6'h00, 32'd0},   // R6 irq masked
        '{OP_WR,   4'd7,  6'h0C, 32'd2},
        '{OP_RD,   4'd7,  6'h0C, 32'd0},
        '{OP_WR,   4'd5,  6'h04, 32'd100},
        '{OP_WR,   4'd5,  6'h00, 32'd100},
        '{OP_WR,   4'd5,  6'h0C, 32'd4},
        '{OP_OUT,  4'd5,  6'h00, 32'd1},   // R5 ch0 drives recovery at equality
        '{OP_RD,   4'd5,  6'h0C, 32'd4},
        '{OP_WR,   4'd10, 6'h0C, 32'd0},
        '{OP_WR,   4'd10, 6'h24, 32'd0},
        '{OP_WR,   4'd10, 6'h20, 32'd0},
        '{OP_WR,   4'd10, 6'h2C, 32'd4},
        '{OP_OUT,  4'd10, 6'h00, 32'd2},   // R10 immediate request
        '{OP_RD,   4'd10, 6'h20, 32'd0},
        '{OP_WR,   4'd9,  6'h18, 32'hDEAD},
        '{OP_RD,   4'd9,  6'h18, 32'd0},   // R9 unmapped
        '{OP_RD,   4'd9,  6'h28, 32'd0},
        '{OP_RD,   4'd9,  6'h30, 32'd0},
        '{OP_RD,   4'd9,  6'h2C, 32'd4},
        '{OP_RD,   4'd9,  6'h14, 32'd20}   // R9 stray write left ch1 bite
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input int req, input logic [5:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, "read", rdata, exp);
    endtask

    task automatic do_out(input int req, input logic [2:0] exp);
        #1;
        check(req, "outputs", {29'd0, irq, rst_system_req, rst_recovery_req}, {29'd0, exp});
    endtask

    task automatic do_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR:   do_wr(VECS[i].a, VECS[i].d);
                OP_RD:   do_rd(int'(VECS[i].req), VECS[i].a, VECS[i].d);
                OP_IDLE: repeat (int'(VECS[i].d)) @(negedge clk);
                OP_TICK: do_ticks(int'(VECS[i].d));
                default: do_out(int'(VECS[i].req), VECS[i].d[2:0]);
            endcase
        end

        // R3: saturation of channel 2 with its request kept high
        do_wr(6'h20, 32'hFFFF_FFFE);
        do_ticks(3);
        do_rd(3, 6'h20, 32'hFFFF_FFFF);
        do_out(3, 3'b010);

        // R4: write wins over a tick in the same cycle on channel 1
        tick = 1'b1;
        do_wr(6'h10, 32'd7);
        tick = 1'b0;
        do_rd(4, 6'h10, 32'd7);

        // R1: block reset clears everything again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_rd(1, 6'h2C, 32'd0);
        do_rd(1, 6'h20, 32'd0);
        do_rd(1, 6'h14, 32'd0);
        do_out(1, 3'b000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule